// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog that runs from its own free-running clock, separate from the bus clock that software uses to reach it. An 11-bit prescaler advances on every watchdog-clock cycle, and each time it wraps it steps an 8-bit up-counter. When the up-counter passes 0xFF, the block starts a fixed-length reset pulse. The pulse appears on an internal reset output (active high) and on a reset pin output (active low). The pulse lasts 16 × 2048 watchdog-clock cycles.

Software sees two 8-bit registers through a small request/done port: a control register at address 0 and the counter at address 1. The control register holds codes. 0xA5 stops the watchdog and holds both counting stages at zero. Every other value lets it run. Writing 0x5A arms exactly one write to the counter. That write reloads the counter, clears the prescaler and sets the control register to 0x00, so the watchdog keeps running. Software avoids a timeout by reloading the counter more often than (256 − reload) × 2048 watchdog cycles.

Each bus request crosses into the watchdog domain through a toggle handshake with two-flop synchronizers. The request is served in a single watchdog cycle, and counting stands still for that cycle whenever the request targets the counter.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the control register reads 0xA5, the counter reads 0x00, the internal reset output is 0, the reset pin output is 1, and the bus port is idle.
- R2: While the control register holds 0xA5, the prescaler and the counter stay at zero. Writing 0xA5 to the control register (address 0) while counting is in progress clears the counter.
- R3: A read at address 1 returns the current counter value at any time, and the value is taken in a cycle in which counting is frozen.
- R4: A write to the counter (address 1) while the control register does not hold 0x5A leaves the counter and the prescaler unchanged.
- R5: A counter write while the control register holds 0x5A loads the written value, clears the prescaler, and sets the control register to 0x00.
- R6: While the watchdog is enabled, the prescaler advances once per watchdog cycle and the counter advances once per 2048 cycles. A reload value R therefore leads to a timeout (256 − R) × 2048 cycles after the write.
- R7: A counter step from 0xFF starts a reset pulse in the next cycle. For exactly 16 × 2048 watchdog cycles, the internal reset output is 1 and the reset pin output is 0.
- R8: A cycle in which a counter access (read or write) is served does not advance the prescaler or the counter, so every access delays the timeout by one watchdog cycle.
- R9: While the reset pulse is active, bus writes to either register are ignored and the counter reads 0x00.
- R10: When the reset pulse ends, the control register returns to 0xA5, which leaves the watchdog disabled with zeroed counting stages.
- R11: A request is accepted only when the port is idle (bus_busy low). Each accepted request gives exactly one bus_done pulse with the read data. Requests raised while the port is busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| wd_clk | input | 1 | Free-running watchdog clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| bus_req | input | 1 | One-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_busy | output | 1 | A request is in flight |
| bus_done | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 8 | Read data, valid with bus_done |
| wd_reset_int | output | 1 | Internal reset, high during the pulse |
| rst_pin_n | output | 1 | Reset pin drive, low during the pulse |

## Verification
Two things can fall in the same watchdog cycle: a counter access and a counting step, including the prescaler wrap that would carry the counter from 0xFF into a timeout. The bench provokes this by loading 0xFF and then issuing counter reads back to back across the whole 2048-cycle window. Each read freezes one cycle, so the timeout must not have occurred 64 cycles past its unfrozen time, must occur soon after, and every read in the window must return 0xFF. A second case runs an access-free reload against a narrow timing window and measures the pulse length exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CODE_OFF    = 8'hA5;
    localparam logic [DATA_W-1:0] CODE_UNLOCK = 8'h5A;
    localparam logic [DATA_W-1:0] CODE_RUN    = 8'h00;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_CNT  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic logic code_is_off(input logic [DATA_W-1:0] c);
        return c == CODE_OFF;
    endfunction

    function automatic logic code_is_unlock(input logic [DATA_W-1:0] c);
        return c == CODE_UNLOCK;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wdt_bus_port.sv
module wdt_bus_port
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] rd_wd,
    output bus_op_t           op,
    output logic              req_tgl,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op      <= '0;
            req_tgl <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && req) begin
                op.we    <= we;
                op.sel   <= reg_sel_e'(addr);
                op.wdata <= wdata;
                req_tgl  <= ~req_tgl;
                busy     <= 1'b1;
            end else if (busy && (ack_s == req_tgl)) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                rdata <= rd_wd;
            end
        end
    end

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R11
    op_held_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(op));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PRESC_W     = 11,
    parameter int PULSE_UNITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int LEN = PULSE_UNITS * (2 ** PRESC_W);
    localparam int CW  = $clog2(LEN);
    localparam logic [CW-1:0] LAST_CNT = CW'(LEN - 1);

    logic [CW-1:0] count;

    assign last = active && (count == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            count  <= '0;
        end else if (active) begin
            if (count == LAST_CNT) begin
                active <= 1'b0;
                count  <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end else if (start) begin
            active <= 1'b1;
            count  <= '0;
        end
    end

    // R7
    pulse_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(start));

    // R7
    pulse_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> active);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PRESC_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic              req_s,
    input  logic              pulse_active,
    input  logic              pulse_last,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf_start
);
    logic [DATA_W-1:0]  ctrl;
    logic [PRESC_W-1:0] presc;
    logic [DATA_W-1:0]  cnt;
    logic               seen;

    logic acc, acc_cnt, wr_ctrl, wr_cnt_ok, enabled, tick, presc_wrap;

    assign acc        = req_s != seen;
    assign acc_cnt    = acc && (op.sel == SEL_CNT);
    assign wr_ctrl    = acc && op.we && (op.sel == SEL_CTRL) && !pulse_active;
    assign wr_cnt_ok  = acc_cnt && op.we && code_is_unlock(ctrl) && !pulse_active;
    assign enabled    = !code_is_off(ctrl);
    assign tick       = enabled && !pulse_active && !acc_cnt;
    assign presc_wrap = &presc;
    assign ovf_start  = tick && presc_wrap && (&cnt);
    assign ack        = seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CODE_OFF;
            presc   <= '0;
            cnt     <= '0;
            seen    <= 1'b0;
            rd_data <= '0;
        end else begin
            seen <= req_s;
            if (acc) begin
                rd_data <= (op.sel == SEL_CNT) ? cnt : ctrl;
            end
            if (pulse_last) begin
                ctrl <= CODE_OFF;
            end else if (wr_cnt_ok) begin
                ctrl <= CODE_RUN;
            end else if (wr_ctrl) begin
                ctrl <= op.wdata;
            end
            if (wr_cnt_ok) begin
                cnt   <= op.wdata;
                presc <= '0;
            end else if (!enabled || pulse_active) begin
                presc <= '0;
                cnt   <= '0;
            end else if (tick) begin
                presc <= presc + 1'b1;
                if (presc_wrap) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> (presc == '0 && cnt == '0));

    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_cnt && op.we && !code_is_unlock(ctrl)) |=> (cnt == $past(cnt)));

    // R5
    unlock_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt_ok |=> (cnt == $past(op.wdata) && presc == '0 && ctrl == CODE_RUN));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_cnt && enabled && !pulse_active && !wr_cnt_ok) |=> $stable(presc) && $stable(cnt));

    // R7
    overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_start |=> pulse_active);

    // R9
    pulse_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_active |=> (cnt == '0));

    // R10
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_active) |-> code_is_off(ctrl));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int PRESC_W     = 11,
    parameter int PULSE_UNITS = 16
) (
    input  logic              bus_clk,
    input  logic              wd_clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_busy,
    output logic              bus_done,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_int,
    output logic              rst_pin_n
);
    bus_op_t           op;
    logic              req_tgl, req_s, ack, ack_s;
    logic [DATA_W-1:0] rd_wd;
    logic              ovf_start, pulse_active, pulse_last;

    wdt_bus_port u_port (
        .clk    (bus_clk),
        .rst    (rst),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ack_s  (ack_s),
        .rd_wd  (rd_wd),
        .op     (op),
        .req_tgl(req_tgl),
        .busy   (bus_busy),
        .done   (bus_done),
        .rdata  (bus_rdata)
    );

    wdt_sync #(.W(1)) u_req_sync (
        .clk(wd_clk), .rst(rst), .d(req_tgl), .q(req_s)
    );

    wdt_sync #(.W(1)) u_ack_sync (
        .clk(bus_clk), .rst(rst), .d(ack), .q(ack_s)
    );

    wdt_core #(.PRESC_W(PRESC_W)) u_core (
        .clk         (wd_clk),
        .rst         (rst),
        .op          (op),
        .req_s       (req_s),
        .pulse_active(pulse_active),
        .pulse_last  (pulse_last),
        .ack         (ack),
        .rd_data     (rd_wd),
        .ovf_start   (ovf_start)
    );

    wdt_pulse #(.PRESC_W(PRESC_W), .PULSE_UNITS(PULSE_UNITS)) u_pulse (
        .clk   (wd_clk),
        .rst   (rst),
        .start (ovf_start),
        .active(pulse_active),
        .last  (pulse_last)
    );

    assign wd_reset_int = pulse_active;
    assign rst_pin_n    = ~pulse_active;
endmodule

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;

    logic       bus_clk = 1'b0;
    logic       wd_clk  = 1'b0;
    logic       rst     = 1'b1;
    logic       bus_req = 1'b0;
    logic       bus_we  = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_busy, bus_done, wd_reset_int, rst_pin_n;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    int wd_cyc = 0;

    always #2.5 bus_clk = ~bus_clk;
    always #3.0 wd_clk  = ~wd_clk;
    always @(posedge wd_clk) wd_cyc <= wd_cyc + 1;

    wdt_keyed u_dut (
        .bus_clk(bus_clk), .wd_clk(wd_clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_busy(bus_busy), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .wd_reset_int(wd_reset_int), .rst_pin_n(rst_pin_n)
    );

    // vector fields: we, addr, wdata, expected, compare, requirement number
    localparam int NV = 16;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 4'd1},   // R1 control after reset
        {1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 4'd1},   // R1 counter after reset
        {1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 4'd4},   // R4 locked write, disabled
        {1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 4'd4},   // R4
        {1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 4'd2},   // R2 enable
        {1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 4'd4},   // R4 locked write, enabled
        {1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 4'd4},   // R4
        {1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 4'd5},   // R5 unlock
        {1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 4'd5},   // R5 reload
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 4'd5},   // R5 control cleared
        {1'b0, 1'b1, 8'h00, 8'h40, 1'b1, 4'd3},   // R3 counter read
        {1'b1, 1'b1, 8'h77, 8'h00, 1'b0, 4'd4},   // R4 relock after use
        {1'b0, 1'b1, 8'h00, 8'h40, 1'b1, 4'd4},   // R4
        {1'b1, 1'b0, 8'hA5, 8'h00, 1'b0, 4'd2},   // R2 stop while running
        {1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 4'd2},   // R2 counter cleared
        {1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 4'd2}    // R2
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic we, input logic addr, input logic [7:0] wd,
                            output logic [7:0] rd);
        @(negedge bus_clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge bus_clk);
        bus_req = 1'b0; bus_we = 1'b0;
        while (!bus_done) @(negedge bus_clk);
        rd = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int n, t_rise, t0;

        repeat (10) @(negedge wd_clk);
        rst = 1'b0;
        @(negedge bus_clk);
        // R1 reset state of the outputs
        chk(wd_reset_int == 1'b0, "R1 internal reset", wd_reset_int, 0);
        chk(rst_pin_n == 1'b1, "R1 pin", rst_pin_n, 1);
        chk(bus_busy == 1'b0, "R1 busy", bus_busy, 0);

        for (int i = 0; i < NV; i++) begin
            bus_xfer(VEC[i][22], VEC[i][21], VEC[i][20:13], rd);
            if (VEC[i][4]) begin
                checks++;
                if (rd !== VEC[i][12:5]) begin
                    fails++;
                    $display("FAIL R%0d vector %0d actual=0x%0h expected=0x%0h",
                             VEC[i][3:0], i, rd, VEC[i][12:5]);
                end
            end
        end

        // R11 request while busy is dropped
        @(negedge bus_clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
        @(negedge bus_clk);
        bus_req = 1'b0;
        chk(bus_busy == 1'b1, "R11 busy after accept", bus_busy, 1);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h22;
        @(negedge bus_clk);
        bus_req = 1'b0; bus_we = 1'b0;
        while (!bus_done) @(negedge bus_clk);
        chk(bus_rdata == 8'hA5, "R11 read data", bus_rdata, 8'hA5);
        @(negedge bus_clk);
        chk(bus_done == 1'b0, "R11 single done", bus_done, 0);
        bus_xfer(1'b0, 1'b0, 8'h00, rd);
        chk(rd == 8'hA5, "R11 dropped write", rd, 8'hA5);

        // R6 timeout for reload 0xFE without accesses
        bus_xfer(1'b1, 1'b0, 8'h5A, rd);
        bus_xfer(1'b1, 1'b1, 8'hFE, rd);
        n = 0;
        while (!wd_reset_int && n < 5000) begin @(negedge wd_clk); n++; end
        chk(n >= 4080 && n <= 4100, "R6 timeout cycles", n, 4094);
        chk(rst_pin_n == 1'b0, "R7 pin low", rst_pin_n, 0);
        t_rise = wd_cyc;

        // R9 writes during the pulse are ignored
        bus_xfer(1'b1, 1'b0, 8'h5A, rd);
        bus_xfer(1'b1, 1'b1, 8'h33, rd);
        bus_xfer(1'b0, 1'b1, 8'h00, rd);
        chk(rd == 8'h00, "R9 counter in pulse", rd, 0);
        bus_xfer(1'b0, 1'b0, 8'h00, rd);
        chk(rd == 8'h00, "R9 control in pulse", rd, 0);

        n = 0;
        while (wd_reset_int && n < 40000) begin @(negedge wd_clk); n++; end
        chk((wd_cyc - t_rise) == 32768, "R7 pulse length", wd_cyc - t_rise, 32768);
        chk(rst_pin_n == 1'b1, "R7 pin released", rst_pin_n, 1);
        bus_xfer(1'b0, 1'b0, 8'h00, rd);
        chk(rd == 8'hA5, "R10 control after pulse", rd, 8'hA5);
        bus_xfer(1'b0, 1'b1, 8'h00, rd);
        chk(rd == 8'h00, "R10 counter after pulse", rd, 0);

        // R8 reads stream across the overflow window of reload 0xFF
        bus_xfer(1'b1, 1'b0, 8'h5A, rd);
        bus_xfer(1'b1, 1'b1, 8'hFF, rd);
        t0 = wd_cyc;
        while ((wd_cyc - t0) < 2048 + 64) begin
            bus_xfer(1'b0, 1'b1, 8'h00, rd);
            chk(rd == 8'hFF, "R3 counter during reads", rd, 8'hFF);
        end
        chk(wd_reset_int == 1'b0, "R8 timeout delayed by reads", wd_reset_int, 0);
        n = 0;
        while (!wd_reset_int && n < 2000) begin @(negedge wd_clk); n++; end
        chk(wd_reset_int == 1'b1, "R8 timeout still reached", wd_reset_int, 1);
        n = 0;
        while (wd_reset_int && n < 40000) begin @(negedge wd_clk); n++; end
        bus_xfer(1'b0, 1'b0, 8'h00, rd);
        chk(rd == 8'hA5, "R10 control after second pulse", rd, 8'hA5);

        finish_run();
    end
endmodule